// File: doc/BRIEF.md
# Reset-Latched Fuse Word Register

This block presents four 8-bit one-time-programmable fuse macros to a Wishbone slave port as one 32-bit word. When reset is released, it drives a sense strobe to the fuse array for a fixed number of cycles. In the last of those cycles it captures all 32 fuse bits into flops and raises a ready flag. From then on, bus reads return the captured word and never touch the array, so reads cost nothing in array timing. The captured word is refreshed only by the next reset.

Programming is started by a Wishbone write. Each fuse bit has its own program-enable line. A write selects which bits to blow through its set data bits and its byte selects. The block then holds the enables of the chosen bits high for a fixed pulse length. Bits that the captured word already shows as blown are never pulsed again. The fuse array, its analog behaviour and power sequencing are outside the block. Reset is active-low and must be held until supply is stable.

Top module: `fuse_word_reg`

## Requirements
- R1: While `rst_n` is low, `fuse_sense`, `word_ready`, `wb_ack`, every bit of `fuse_prog` and every bit of `wb_dat_o` are 0.
- R2: After the first rising clock edge with `rst_n` high, `fuse_sense` is 1 for exactly SENSE_CYCLES consecutive cycles and then stays 0 until the next reset. No program enable is high while it is 1.
- R3: On the edge that ends the sense window, all 32 bits of `fuse_q` are captured and `word_ready` rises. Bit i of the word is bit i mod 8 of macro i/8. `fuse_q` is ignored at all other times.
- R4: Once set, `word_ready` stays 1 and the captured word stays constant until reset.
- R5: A bus request (`wb_cyc` and `wb_stb` high) is acknowledged by a single-cycle `wb_ack` one cycle after the edge that accepts it. A read returns the captured word, or 0 if `word_ready` was 0 at the accepting edge.
- R6: A write accepted while ready and idle raises `fuse_prog` on each bit b for exactly PROG_CYCLES cycles, starting the cycle after acceptance. The bit must meet three conditions: `wb_dat_i[b]` is 1, `wb_sel[b/8]` is 1, and the captured word has b at 0. The set of enabled bits does not change during the pulse.
- R7: Bits already 1 in the captured word are never pulsed. A write that selects no pulsable bit starts no pulse.
- R8: Writes accepted during sensing or during a pulse are acknowledged but have no effect on `fuse_prog`.
- R9: Programming does not alter the captured word or read data. The new fuse values appear only after the next reset and sense.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, held until power is stable |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | 1 = write (program), 0 = read |
| wb_sel | input | 4 | Byte lane selects, lane k = bits 8k+7..8k |
| wb_dat_i | input | 32 | Write data: 1 = blow this bit |
| wb_dat_o | output | 32 | Read data |
| wb_ack | output | 1 | Single-cycle acknowledge |
| fuse_q | input | 32 | Sensed fuse values from the array |
| fuse_sense | output | 1 | Sense strobe to the array |
| fuse_prog | output | 32 | Per-bit program enables |
| word_ready | output | 1 | Captured word is valid |

## Verification
Each result has a fixed latency. Sense rises one cycle after the first released edge. Ready and the captured word follow SENSE_CYCLES cycles later. The acknowledge and read data come one cycle after the accepting edge. Program enables rise the cycle after a write is accepted and fall PROG_CYCLES cycles later. The bench keeps a behavioural model that advances on each rising edge from the inputs the design saw. It compares every output at the following falling edge, so each expected value is sampled in the exact cycle it is due. The behavioural fuse array blows a bit only after a full-length pulse, so a short or misdirected pulse shows up in the refreshed word after the second reset.

// File: rtl/fuse_word_pkg.sv
package fuse_word_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        SQ_WAIT  = 2'd0,
        SQ_SENSE = 2'd1,
        SQ_DONE  = 2'd2
    } seq_state_e;

    typedef enum logic {
        PG_IDLE  = 1'b0,
        PG_PULSE = 1'b1
    } prog_state_e;

    typedef struct packed {
        logic              valid;
        logic [LANES-1:0]  sel;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fuse_sense_seq.sv
module fuse_sense_seq
    import fuse_word_pkg::*;
#(
    parameter int unsigned SENSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fuse_q,
    output logic              sense,
    output logic              ready,
    output logic [WORD_W-1:0] word
);
    localparam int unsigned CW = cnt_width(SENSE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(SENSE_CYCLES - 1);

    seq_state_e    st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SQ_WAIT;
            cnt  <= '0;
            word <= '0;
        end else begin
            unique case (st)
                SQ_WAIT: begin
                    st  <= SQ_SENSE;
                    cnt <= '0;
                end
                SQ_SENSE: begin
                    if (cnt == LAST) begin
                        word <= fuse_q;
                        st   <= SQ_DONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= SQ_DONE;
            endcase
        end
    end

    assign sense = (st == SQ_SENSE);
    assign ready = (st == SQ_DONE);
endmodule

// File: rtl/fuse_prog_ctrl.sv
module fuse_prog_ctrl
    import fuse_word_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_req_t           req,
    input  logic              ready,
    input  logic [WORD_W-1:0] blown,
    output logic [WORD_W-1:0] prog
);
    localparam int unsigned CW = cnt_width(PROG_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

    prog_state_e       st;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] cand;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cand[g*LANE_W +: LANE_W] = req.sel[g]
            ? (req.data[g*LANE_W +: LANE_W] & ~blown[g*LANE_W +: LANE_W])
            : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= PG_IDLE;
            cnt  <= '0;
            prog <= '0;
        end else begin
            unique case (st)
                PG_IDLE: begin
                    if (req.valid && ready && (cand != '0)) begin
                        prog <= cand;
                        cnt  <= '0;
                        st   <= PG_PULSE;
                    end
                end
                default: begin
                    if (cnt == LAST) begin
                        prog <= '0;
                        st   <= PG_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fuse_bus_port.sv
module fuse_bus_port
    import fuse_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [LANES-1:0]  sel,
    input  logic [WORD_W-1:0] dat_i,
    input  logic              ready,
    input  logic [WORD_W-1:0] word,
    output logic              ack,
    output logic [WORD_W-1:0] dat_o,
    output wr_req_t           req
);
    logic take;

    assign take = cyc && stb && !ack;

    always_comb begin
        req.valid = take && we;
        req.sel   = sel;
        req.data  = dat_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            dat_o <= '0;
        end else begin
            ack <= take;
            if (take && !we) begin
                dat_o <= ready ? word : '0;
            end
        end
    end
endmodule

// File: rtl/fuse_word_reg.sv
module fuse_word_reg
    import fuse_word_pkg::*;
#(
    parameter int unsigned SENSE_CYCLES = 4,
    parameter int unsigned PROG_CYCLES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [LANES-1:0]  wb_sel,
    input  logic [WORD_W-1:0] wb_dat_i,
    output logic [WORD_W-1:0] wb_dat_o,
    output logic              wb_ack,
    input  logic [WORD_W-1:0] fuse_q,
    output logic              fuse_sense,
    output logic [WORD_W-1:0] fuse_prog,
    output logic              word_ready
);
    logic [WORD_W-1:0] latched_word;
    wr_req_t           wr_req;

    fuse_sense_seq #(.SENSE_CYCLES(SENSE_CYCLES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .fuse_q(fuse_q),
        .sense (fuse_sense),
        .ready (word_ready),
        .word  (latched_word)
    );

    fuse_bus_port u_bus (
        .clk  (clk),
        .rst_n(rst_n),
        .cyc  (wb_cyc),
        .stb  (wb_stb),
        .we   (wb_we),
        .sel  (wb_sel),
        .dat_i(wb_dat_i),
        .ready(word_ready),
        .word (latched_word),
        .ack  (wb_ack),
        .dat_o(wb_dat_o),
        .req  (wr_req)
    );

    fuse_prog_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (wr_req),
        .ready(word_ready),
        .blown(latched_word),
        .prog (fuse_prog)
    );
endmodule

// File: rtl/fuse_word_checker.sv
module fuse_word_checker
    import fuse_word_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wb_cyc,
    input logic              wb_stb,
    input logic              wb_we,
    input logic              wb_ack,
    input logic [WORD_W-1:0] wb_dat_o,
    input logic              fuse_sense,
    input logic [WORD_W-1:0] fuse_prog,
    input logic              word_ready,
    input logic [WORD_W-1:0] latched_word
);
    AST_SENSE_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_sense |-> (fuse_prog == '0)); // R2
    AST_SENSE_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fuse_sense && word_ready)); // R3
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |=> word_ready); // R4
    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |=> $stable(latched_word)); // R9
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack); // R5
    AST_ZERO_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc && wb_stb && !wb_we && !wb_ack && !word_ready) |=> (wb_ack && wb_dat_o == '0)); // R5
    AST_PROG_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_prog != '0) |-> word_ready); // R6
    AST_PULSE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ((fuse_prog != '0) && ($past(fuse_prog) != '0)) |-> $stable(fuse_prog)); // R6
    AST_NO_REBLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((fuse_prog & latched_word) == '0)); // R7
endmodule

bind fuse_word_reg fuse_word_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_cyc      (wb_cyc),
    .wb_stb      (wb_stb),
    .wb_we       (wb_we),
    .wb_ack      (wb_ack),
    .wb_dat_o    (wb_dat_o),
    .fuse_sense  (fuse_sense),
    .fuse_prog   (fuse_prog),
    .word_ready  (word_ready),
    .latched_word(latched_word)
);

// File: tb/sim_fuse_word_reg.sv
`timescale 1ns/1ps
module sim_fuse_word_reg;
    localparam int S = 4;
    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
    logic [3:0]  wb_sel = '0;
    logic [31:0] wb_dat_i = '0;
    logic [31:0] wb_dat_o;
    logic        wb_ack;
    logic [31:0] fuse_q;
    logic        fuse_sense;
    logic [31:0] fuse_prog;
    logic        word_ready;

    logic [31:0] fuse_arr = 32'h0000_A501;
    int          pulse_len [32];
    int          n_chk = 0, n_bad = 0;
    bit          started = 1'b0;
    int          sense_seen = 0;

    // model state
    int          m_phase = 0, m_cnt = 0;
    bit          m_ready = 0, m_ack = 0;
    logic [31:0] m_lat = '0, m_prog = '0, m_dat = '0;

    always #10 clk = ~clk;

    assign fuse_q = fuse_sense ? fuse_arr : 32'h0;

    fuse_word_reg #(.SENSE_CYCLES(S), .PROG_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_sel(wb_sel), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack),
        .fuse_q(fuse_q), .fuse_sense(fuse_sense), .fuse_prog(fuse_prog),
        .word_ready(word_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_ready = 0; m_ack = 0;
            m_lat = '0; m_prog = '0; m_dat = '0;
        end else begin
            bit acc;
            logic [31:0] msk;
            acc = wb_cyc && wb_stb && !m_ack;
            if (acc && !wb_we) m_dat = m_ready ? m_lat : 32'h0;
            msk = '0;
            for (int k = 0; k < 4; k++)
                if (wb_sel[k]) msk[k*8 +: 8] = wb_dat_i[k*8 +: 8] & ~m_lat[k*8 +: 8];
            if (m_phase == 0) begin
                m_phase = 1; m_cnt = 0;
            end else if (m_phase == 1) begin
                if (m_cnt == S-1) begin m_lat = fuse_arr; m_ready = 1; m_phase = 2; end
                else m_cnt++;
            end else if (m_phase == 2) begin
                if (acc && wb_we && msk != 0) begin m_prog = msk; m_cnt = 0; m_phase = 3; end
            end else begin
                if (m_cnt == P-1) begin m_prog = '0; m_phase = 2; end
                else m_cnt++;
            end
            m_ack = acc;
        end
    end

    // per-cycle comparison and fuse array behaviour
    always @(negedge clk) begin
        if (started) begin
            check("R2 sense", {31'b0, fuse_sense}, {31'b0, m_phase == 1});
            check("R3 ready", {31'b0, word_ready}, {31'b0, m_ready});
            check("R6 prog", fuse_prog, m_prog);
            check("R5 ack", {31'b0, wb_ack}, {31'b0, m_ack});
            check("R5 data", wb_dat_o, m_dat);
        end
        if (!rst_n) sense_seen = 0;
        else if (fuse_sense) sense_seen++;
        for (int i = 0; i < 32; i++) begin
            if (fuse_prog[i]) pulse_len[i]++;
            else pulse_len[i] = 0;
            if (pulse_len[i] == P) fuse_arr[i] = 1'b1;
        end
    end

    task automatic bus(input bit we, input logic [3:0] sel, input logic [31:0] d,
                       output logic [31:0] rd);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = we; wb_sel = sel; wb_dat_i = d;
        @(negedge clk);
        while (!wb_ack) @(negedge clk);
        rd = wb_dat_o;
        wb_cyc = 0; wb_stb = 0; wb_we = 0; wb_sel = '0; wb_dat_i = '0;
    endtask

    task automatic wait_ready();
        while (!word_ready) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < 32; i++) pulse_len[i] = 0;
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check("R1 reset outputs",
              {fuse_sense, word_ready, wb_ack, 29'b0} | fuse_prog | wb_dat_o, 32'h0);
        rst_n = 1;
        // R5: read during sensing returns zero; R8: write during sensing ignored
        bus(1'b0, 4'hF, 32'h0, rd);
        check("R5 read before ready", rd, 32'h0);
        bus(1'b1, 4'hF, 32'hFFFF_FFFF, rd);
        check("R8 write while sensing", fuse_prog, 32'h0);
        wait_ready();
        check("R2 sense length", sense_seen, S);
        bus(1'b0, 4'hF, 32'h0, rd);
        check("R3 captured word", rd, 32'h0000_A501);
        // R6: lanes 0 and 2 selected, bit 0 already blown
        bus(1'b1, 4'b0101, 32'h1234_56FF, rd);
        check("R6 pulse bits", fuse_prog, 32'h0034_00FE);
        // R8: write during pulse ignored
        bus(1'b1, 4'hF, 32'hFF00_0000, rd);
        check("R8 write during pulse", fuse_prog, 32'h0034_00FE);
        repeat (P + 2) @(negedge clk);
        check("R6 pulse ended", fuse_prog, 32'h0);
        check("R6 array blown", fuse_arr, 32'h0034_A5FF);
        // R7: already-blown bit gives no pulse
        bus(1'b1, 4'h1, 32'h0000_0001, rd);
        check("R7 no reblow", fuse_prog, 32'h0);
        repeat (2) @(negedge clk);
        check("R7 still idle", fuse_prog, 32'h0);
        // R9: word not refreshed until reset
        bus(1'b0, 4'hF, 32'h0, rd);
        check("R9 word frozen", rd, 32'h0000_A501);
        check("R4 ready held", {31'b0, word_ready}, 32'h1);
        rst_n = 0;
        repeat (2) @(negedge clk);
        check("R1 ready cleared", {31'b0, word_ready}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        wait_ready();
        bus(1'b0, 4'hF, 32'h0, rd);
        check("R9 word refreshed", rd, 32'h0034_A5FF);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule